// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block is a small fully associative table that lets a compiler hoist a load above earlier stores that might write the same bytes. The hoisted ("advanced") load records its destination register tag, its doubleword base and the bytes it touched. Each later store is compared against every live record, and every record whose bytes overlap the store's bytes is dropped. When the program reaches the load's original position it issues a check by register tag. The check passes only if the record is still present. A record that was dropped for any reason fails the check, so the fixup path runs, and that outcome is always safe.

Records are keyed by register tag, and each tag owns at most one record. A new advanced load to a tag that already has a record replaces that record. When every slot is in use, a round-robin pointer picks the slot to overwrite. A passing check normally frees its record. A keep flag on the check leaves the record in place.

Top module: `slc_check_table`

## Requirements
- R1: After reset the table holds no records, so every check fails (`chk_pass_o`=0).
- R2: A load on `ld_valid_i` records `ld_tag_i`, `ld_addr_i` and `ld_size_i` at the clock edge. A check of that tag in any later cycle passes while the record lives.
- R3: `chk_pass_o` is combinational. It is 1 only when `chk_valid_i`=1 and a valid record holds `chk_tag_i` in the table as it stood at the start of the cycle. It is 0 whenever `chk_valid_i`=0.
- R4: Two accesses overlap when address bits [ADDR_W-1:3] are equal and their byte masks intersect. The byte mask is ((1<<bytes)-1)<<addr[2:0], where size code 0,1,2,3 means 1,2,4,8 bytes. Accesses do not cross an 8-byte boundary. A store on `st_valid_i` invalidates every record that overlaps it.
- R5: A store that overlaps no record, whether by a different doubleword or by disjoint bytes in the same doubleword, leaves all records valid.
- R6: A load to a tag that already has a live record overwrites that record. Only the new address is tracked afterwards, and no second record is created.
- R7: A new tag goes to the lowest-numbered free slot. If no slot is free, it overwrites the slot named by a round-robin pointer. The pointer starts at 0 and advances by one, with wrap, on each such eviction only. A check of the evicted tag then fails.
- R8: A passing check with `chk_keep_i`=0 frees its record. With `chk_keep_i`=1 the record stays.
- R9: Within one cycle the store is applied first, then the check's freeing, then the load. A load issued in the same cycle as an overlapping store, or as a freeing check of the same tag, leaves a live record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Advanced load inserts a record |
| ld_tag_i | input | TAG_W | Destination register tag of the load |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | 2 | Load size code (log2 bytes) |
| st_valid_i | input | 1 | Store is searched against all records |
| st_addr_i | input | ADDR_W | Store byte address |
| st_size_i | input | 2 | Store size code (log2 bytes) |
| chk_valid_i | input | 1 | Check request |
| chk_tag_i | input | TAG_W | Register tag being checked |
| chk_keep_i | input | 1 | Keep the record after a passing check |
| chk_pass_o | output | 1 | Check result, same cycle |

## Verification
The check result is due in the same cycle as the request and reflects only the effects of earlier edges. The bench therefore drives each request on the falling edge and samples `chk_pass_o` one time step later, before the next rising edge. Loads, stores and freeing checks take effect at the following rising edge, so the bench model applies them in the R9 order right after each sample. Their effect is then seen by the check of the next cycle. Directed sequences cover table fill and successive evictions, same-tag replacement, disjoint bytes in one doubleword, and same-cycle collisions. Seeded random traffic over a few tags and doublewords covers the rest.

// File: rtl/slc_pkg.sv
package slc_pkg;
  // byte lanes touched inside an 8-byte doubleword
  function automatic logic [7:0] lane_mask(input logic [2:0] off, input logic [1:0] sz);
    logic [7:0] m;
    case (sz)
      2'd0:    m = 8'h01;
      2'd1:    m = 8'h03;
      2'd2:    m = 8'h0f;
      default: m = 8'hff;
    endcase
    return m << off;
  endfunction
endpackage

// File: rtl/slc_overlap.sv
module slc_overlap #(
  parameter int BASE_W = 29
) (
  input  logic              valid_i,
  input  logic [BASE_W-1:0] base_a_i,
  input  logic [7:0]        mask_a_i,
  input  logic [BASE_W-1:0] base_b_i,
  input  logic [7:0]        mask_b_i,
  output logic              hit_o
);
  assign hit_o = valid_i && (base_a_i == base_b_i) && ((mask_a_i & mask_b_i) != 8'h00);
endmodule

// File: rtl/slc_pick.sv
module slc_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/slc_check_table.sv
module slc_check_table #(
  parameter int N      = 8,
  parameter int TAG_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [1:0]        ld_size_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [1:0]        st_size_i,
  input  logic              chk_valid_i,
  input  logic [TAG_W-1:0]  chk_tag_i,
  input  logic              chk_keep_i,
  output logic              chk_pass_o
);
  import slc_pkg::*;

  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;
  localparam int BASE_W = ADDR_W - 3;

  logic [N-1:0]        valid_q;
  logic [TAG_W-1:0]    tag_q  [N];
  logic [BASE_W-1:0]   base_q [N];
  logic [7:0]          mask_q [N];
  logic [IDX_W-1:0]    rr_q;

  logic [7:0]   st_mask, ld_mask;
  logic [N-1:0] ov_hit, st_hit, chk_hit, clr, valid_mid, ld_match;
  logic [N-1:0] free_oh, rep_oh, rr_oh, sel_oh;
  logic         free_any, rep_any, evict;

  assign st_mask = lane_mask(st_addr_i[2:0], st_size_i);
  assign ld_mask = lane_mask(ld_addr_i[2:0], ld_size_i);

  for (genvar i = 0; i < N; i++) begin : g_ent
    slc_overlap #(.BASE_W(BASE_W)) u_ov (
      .valid_i (valid_q[i]),
      .base_a_i(base_q[i]),
      .mask_a_i(mask_q[i]),
      .base_b_i(st_addr_i[ADDR_W-1:3]),
      .mask_b_i(st_mask),
      .hit_o   (ov_hit[i])
    );
    assign st_hit[i]   = st_valid_i && ov_hit[i];
    assign chk_hit[i]  = valid_q[i] && (tag_q[i] == chk_tag_i);
    assign ld_match[i] = valid_mid[i] && (tag_q[i] == ld_tag_i);
    assign rr_oh[i]    = (rr_q == IDX_W'(i));
  end

  assign chk_pass_o = chk_valid_i && (chk_hit != '0);
  assign clr        = (chk_pass_o && !chk_keep_i) ? chk_hit : '0;
  // store first, then check release, then insert
  assign valid_mid  = valid_q & ~st_hit & ~clr;

  slc_pick #(.N(N)) u_rep  (.req_i(ld_match),   .gnt_o(rep_oh),  .any_o(rep_any));
  slc_pick #(.N(N)) u_free (.req_i(~valid_mid), .gnt_o(free_oh), .any_o(free_any));

  assign evict  = ld_valid_i && !rep_any && !free_any;
  assign sel_oh = rep_any ? rep_oh : (free_any ? free_oh : rr_oh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i]  <= '0;
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else begin
      valid_q <= valid_mid | (ld_valid_i ? sel_oh : '0);
      for (int i = 0; i < N; i++) begin
        if (ld_valid_i && sel_oh[i]) begin
          tag_q[i]  <= ld_tag_i;
          base_q[i] <= ld_addr_i[ADDR_W-1:3];
          mask_q[i] <= ld_mask;
        end
      end
      if (evict) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R3
  pass_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_pass_o |-> chk_valid_i);
  // R6
  tag_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chk_hit));
  // R4
  store_kills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !ld_valid_i) |=> ((valid_q & $past(st_hit)) == '0));
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_pass_o && !chk_keep_i && !ld_valid_i) |=> ((valid_q & $past(chk_hit)) == '0));
  // R7
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |-> $onehot(sel_oh));

  for (genvar i = 0; i < N; i++) begin : g_asrt
    // R9
    insert_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_valid_i && sel_oh[i]) |=> (valid_q[i] && tag_q[i] == $past(ld_tag_i)));
  end
endmodule

// File: tb/slc_check_table_tb.sv
module slc_check_table_tb;
  localparam int N = 8, TAG_W = 7, ADDR_W = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ld_valid_i = 0, st_valid_i = 0, chk_valid_i = 0, chk_keep_i = 0;
  logic [TAG_W-1:0] ld_tag_i = '0, chk_tag_i = '0;
  logic [ADDR_W-1:0] ld_addr_i = '0, st_addr_i = '0;
  logic [1:0] ld_size_i = '0, st_size_i = '0;
  logic chk_pass_o;

  int checks = 0, errors = 0;
  bit m_v [N];
  int m_tag [N];
  int m_base [N];
  int m_mask [N];
  int m_rr;

  always #4 clk_i = ~clk_i;

  slc_check_table #(.N(N), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_dut (.*);

  function automatic int mk_mask(int addr, int sz);
    int nb = 1 << sz;
    return (((1 << nb) - 1) << (addr % 8)) & 255;
  endfunction

  function automatic bit model_lookup(int tag);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == tag) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_step(bit lv, int lt, int la, int ls, bit sv, int sa, int ss,
                            bit cv, int ct, bit ck);
    int sel;
    bit pass;
    pass = cv && model_lookup(ct);
    for (int i = 0; i < N; i++)
      if (sv && m_v[i] && m_base[i] == sa / 8 && (m_mask[i] & mk_mask(sa, ss)) != 0) m_v[i] = 0;
    if (pass && !ck)
      for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == ct) m_v[i] = 0;
    if (lv) begin
      sel = -1;
      for (int i = 0; i < N; i++) if (sel < 0 && m_v[i] && m_tag[i] == lt) sel = i;
      for (int i = 0; i < N; i++) if (sel < 0 && !m_v[i]) sel = i;
      if (sel < 0) begin
        sel = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[sel] = 1; m_tag[sel] = lt; m_base[sel] = la / 8; m_mask[sel] = mk_mask(la, ls);
    end
  endtask

  task automatic cyc(string req, bit lv, int lt, int la, int ls, bit sv, int sa, int ss,
                     bit cv, int ct, bit ck);
    bit exp;
    @(negedge clk_i);
    ld_valid_i = lv; ld_tag_i = TAG_W'(lt); ld_addr_i = ADDR_W'(la); ld_size_i = 2'(ls);
    st_valid_i = sv; st_addr_i = ADDR_W'(sa); st_size_i = 2'(ss);
    chk_valid_i = cv; chk_tag_i = TAG_W'(ct); chk_keep_i = ck;
    #1;
    exp = cv && model_lookup(ct);
    checks++;
    if (chk_pass_o !== exp) begin
      errors++;
      $display("FAIL %s tag=%0d actual=%0b expected=%0b", req, ct, chk_pass_o, exp);
    end
    model_step(lv, lt, la, ls, sv, sa, ss, cv, ct, ck);
  endtask

  task automatic ld(string r, int t, int a, int s); cyc(r, 1, t, a, s, 0, 0, 0, 0, 0, 0); endtask
  task automatic st(string r, int a, int s);        cyc(r, 0, 0, 0, 0, 1, a, s, 0, 0, 0); endtask
  task automatic ck(string r, int t, bit k);        cyc(r, 0, 0, 0, 0, 0, 0, 0, 1, t, k); endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    ld_valid_i = 0; st_valid_i = 0; chk_valid_i = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    ck("R1", 3, 1);
    ck("R1", 0, 0);
    // R2 insert and check
    ld("R2", 5, 32'h100, 3);
    ck("R2", 5, 1);
    cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0, 5, 0);  // no request -> no pass
    // R4 overlapping store
    st("R4", 32'h104, 0);
    ck("R4", 5, 1);
    // R5 disjoint bytes / other doubleword
    ld("R5", 6, 32'h200, 1);
    st("R5", 32'h204, 2);
    st("R5", 32'h208, 3);
    ck("R5", 6, 1);
    // R8 release vs keep
    ck("R8", 6, 0);
    ck("R8", 6, 1);
    // R6 replacement
    ld("R6", 7, 32'h300, 3);
    ld("R6", 7, 32'h400, 3);
    st("R6", 32'h300, 3);
    ck("R6", 7, 1);
    st("R6", 32'h402, 1);
    ck("R6", 7, 1);
    // R9 store and insert together
    cyc("R9", 1, 9, 32'h500, 3, 1, 32'h500, 3, 0, 0, 0);
    ck("R9", 9, 1);
    cyc("R9", 1, 9, 32'h600, 2, 0, 0, 0, 1, 9, 0);
    ck("R9", 9, 1);
    // R7 fill and round-robin evict
    do_reset();
    for (int t = 1; t <= N; t++) ld("R7", t, t * 64, 3);
    ld("R7", 20, 32'h1000, 3);
    ck("R7", 1, 1);
    ck("R7", 2, 1);
    ld("R7", 21, 32'h1100, 3);
    ck("R7", 2, 1);
    ck("R7", 3, 1);
    ck("R7", 20, 1);
    // random mix
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int ls, ss;
      ls = $urandom % 4; ss = $urandom % 4;
      cyc("R3", ($urandom % 3) == 0, $urandom % 12,
          (($urandom % 4) * 8) + (($urandom % 8) & ~((1 << ls) - 1)), ls,
          ($urandom % 3) == 0,
          (($urandom % 4) * 8) + (($urandom % 8) & ~((1 << ss) - 1)), ss,
          ($urandom % 2) == 0, $urandom % 12, ($urandom % 2) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule